// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital search engine of a sampled successive-approximation converter. When a conversion is requested, it first asks the external sample-and-hold circuit to capture the input, and it does this once for the whole conversion. It then spends one clock on each output bit, working from the most significant bit down to the least significant. In every trial it presents a code to an external DAC and reads one comparator bit back. That bit decides whether the bit under test stays set in the code.

The DAC, the comparator and the hold circuit sit outside the block. The comparator bit must be valid during the cycle in which the trial code is driven, and it must be high when the DAC estimate is below the held input. When the last bit is decided, the finished code is registered. That code stays on the result port until the next conversion finishes. A one-cycle done pulse marks the moment the new code appears.

Top module: `sar_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `done_o` and `sample_o` are 0, and `result_o` and `dac_code_o` are all zeros.
- R2: A `start_i` seen high at a clock edge while idle makes `sample_o` high for exactly the next cycle, and `busy_o` goes high in that same cycle.
- R3: In the cycle after the sample cycle, `dac_code_o` carries the first trial, which has only bit N-1 set (half of full scale).
- R4: Bits are tried one per clock from N-1 down to 0. At each edge of a trial, the bit under test stays 1 if `cmp_i` is 1 and is cleared if `cmp_i` is 0. In the same edge, the next lower bit is set as the new trial. Bits below the trial bit are always 0.
- R5: A conversion uses exactly N trial cycles. `done_o` is high for exactly one cycle, starting at the edge that decides bit 0, and `busy_o` is low in that cycle.
- R6: `result_o` takes the decided code at the edge that raises `done_o`. It does not change at any other time, so the previous result is kept throughout the next conversion.
- R7: A `start_i` that arrives while `busy_o` is high is ignored. It produces no sample pulse, and the running conversion finishes with unchanged timing and result.
- R8: The input is captured only during the sample cycle. Input changes after that cycle do not change the result.
- R9: Inputs at zero and at full scale convert to all-zeros and all-ones codes.
- R10: A start in the cycle where `done_o` is high is accepted, so conversions can run back to back every N+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous |
| start_i | input | 1 | Conversion request, acted on while idle |
| cmp_i | input | 1 | Comparator: 1 when the DAC estimate is below the held input |
| sample_o | output | 1 | One-cycle hold-capture strobe |
| dac_code_o | output | N | Trial code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when a new result is registered |
| result_o | output | N | Last finished code |

## Verification
A corrupted bit pointer shows up at once on `dac_code_o`. The next trial code has the wrong bit set, or stray bits set below the trial bit, so a per-cycle comparison against the expected search sequence catches it within one clock. A wrong keep-or-clear decision shows up on the following trial code and again in the final result. A fault in the state sequencing moves `sample_o` or `done_o` away from their fixed offsets of 1 and N+2 cycles after the start edge, or gives a second sample pulse after a start that should have been ignored. The expected codes come from an ideal held-input model in the bench.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_TRIAL  = 2'd2
    } sar_state_e;

endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int N = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    output logic         sample_o,
    output logic         busy_o,
    output logic         load_msb_o,
    output logic         step_o,
    output logic [N-1:0] ptr_o
);

    localparam logic [N-1:0] TOP_BIT = {1'b1, {(N-1){1'b0}}};

    typedef struct packed {
        sar_state_e   st;
        logic         smp;
        logic [N-1:0] ptr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.smp = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st  = ST_SAMPLE;
                    seq_d.smp = 1'b1;
                end
            end
            ST_SAMPLE: begin
                seq_d.st  = ST_TRIAL;
                seq_d.ptr = TOP_BIT;
            end
            ST_TRIAL: begin
                seq_d.ptr = seq_q.ptr >> 1;
                if (seq_q.ptr[0]) begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: begin
                seq_d.st  = ST_IDLE;
                seq_d.ptr = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q.st  <= ST_IDLE;
            seq_q.smp <= 1'b0;
            seq_q.ptr <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sample_o   = seq_q.smp;
    assign busy_o     = (seq_q.st != ST_IDLE);
    assign load_msb_o = (seq_q.st == ST_SAMPLE);
    assign step_o     = (seq_q.st == ST_TRIAL);
    assign ptr_o      = seq_q.ptr;

    // R2
    sample_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |=> !sample_o);

    // R4
    ptr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ptr_o) && (step_o -> $onehot(ptr_o)));

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> !sample_o);

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int N = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_msb_i,
    input  logic         step_i,
    input  logic [N-1:0] ptr_i,
    input  logic         cmp_i,
    output logic [N-1:0] trial_o,
    output logic [N-1:0] decided_o
);

    localparam logic [N-1:0] TOP_BIT = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] trial_d, trial_q;
    logic [N-1:0] kept;

    always_comb begin
        kept    = (trial_q & ~ptr_i) | (cmp_i ? ptr_i : '0);
        trial_d = trial_q;
        if (load_msb_i) begin
            trial_d = TOP_BIT;
        end else if (step_i) begin
            trial_d = kept | (ptr_i >> 1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            trial_q <= '0;
        end else begin
            trial_q <= trial_d;
        end
    end

    assign trial_o   = trial_q;
    assign decided_o = kept;

    // R4
    low_bits_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |-> ((trial_q & (ptr_i - 1'b1)) == '0) && ((trial_q & ptr_i) != '0));

    // R4
    upper_bits_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !ptr_i[0]) |=> ((trial_q & ~($past(ptr_i) | ($past(ptr_i) >> 1)))
                                   == ($past(trial_q) & ~($past(ptr_i) | ($past(ptr_i) >> 1)))));

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
    parameter int N = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         finish_i,
    input  logic [N-1:0] decided_i,
    output logic [N-1:0] result_o,
    output logic         done_o
);

    typedef struct packed {
        logic [N-1:0] code;
        logic         done;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d      = res_q;
        res_d.done = finish_i;
        if (finish_i) begin
            res_d.code = decided_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            res_q.code <= '0;
            res_q.done <= 1'b0;
        end else begin
            res_q <= res_d;
        end
    end

    assign result_o = res_q.code;
    assign done_o   = res_q.done;

    // R5
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R6
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
    parameter int N = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         cmp_i,
    output logic         sample_o,
    output logic [N-1:0] dac_code_o,
    output logic         busy_o,
    output logic         done_o,
    output logic [N-1:0] result_o
);

    localparam logic [N-1:0] TOP_BIT = {1'b1, {(N-1){1'b0}}};

    logic         load_msb;
    logic         step;
    logic [N-1:0] ptr;
    logic [N-1:0] decided;
    logic         finish;

    sar_sequencer #(.N(N)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .sample_o   (sample_o),
        .busy_o     (busy_o),
        .load_msb_o (load_msb),
        .step_o     (step),
        .ptr_o      (ptr)
    );

    sar_trial_reg #(.N(N)) u_trial (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_msb_i (load_msb),
        .step_i     (step),
        .ptr_i      (ptr),
        .cmp_i      (cmp_i),
        .trial_o    (dac_code_o),
        .decided_o  (decided)
    );

    assign finish = step & ptr[0];

    sar_result_reg #(.N(N)) u_res (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .finish_i  (finish),
        .decided_i (decided),
        .result_o  (result_o),
        .done_o    (done_o)
    );

    // R3
    first_trial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |=> (dac_code_o == TOP_BIT) && busy_o);

    // R5
    done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o && !sample_o);

    // R2
    start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> sample_o && busy_o);

endmodule

// File: tb/sar_ctrl_tb.sv
module sar_ctrl_tb;

    localparam int N    = 10;
    localparam int FULL = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp;
    logic         sample;
    logic [N-1:0] dac_code;
    logic         busy;
    logic         done;
    logic [N-1:0] result;

    int vin  = 0;
    int held = 0;
    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    int exp_q[$];

    always #4 clk = ~clk;

    sar_ctrl #(.N(N)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .cmp_i      (cmp),
        .sample_o   (sample),
        .dac_code_o (dac_code),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (result)
    );

    // ideal hold circuit and comparator; held value sits half an LSB above code
    always @(posedge clk) if (sample) held <= vin;
    assign cmp = (int'(dac_code) <= held);

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected done", 1, 0);
            end else begin
                check("R6 result", int'(result), exp_q.pop_front());
            end
        end
    end

    task automatic convert(input int v, input bit change_after, input bit poke_busy);
        int old_res;
        @(negedge clk);
        vin = v;
        start = 1'b1;
        old_res = int'(result);
        exp_q.push_back(v);
        @(posedge clk); #1;
        start = 1'b0;
        check("R2 sample high", int'(sample), 1);
        check("R2 busy", int'(busy), 1);
        @(posedge clk); #1;
        if (change_after) vin = FULL - v;
        check("R2 sample one cycle", int'(sample), 0);
        check("R3 first trial", int'(dac_code), 1 << (N - 1));
        check("R6 old result held", int'(result), old_res);
        for (int k = N - 1; k >= 0; k--) begin
            int expc;
            expc = ((v >> (k + 1)) << (k + 1)) | (1 << k);
            check("R4 trial code", int'(dac_code), expc);
            check("R5 no early done", int'(done), 0);
            if (poke_busy && k == N / 2) start = 1'b1;
            @(posedge clk); #1;
            if (poke_busy && k == N / 2) begin
                start = 1'b0;
                check("R7 no sample while busy", int'(sample), 0);
            end
        end
        check("R5 done pulse", int'(done), 1);
        check("R5 busy low", int'(busy), 0);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 sample", int'(sample), 0);
        check("R1 result", int'(result), 0);
        check("R1 dac", int'(dac_code), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", int'(busy), 0);

        convert(613, 1'b0, 1'b0);
        convert(0, 1'b0, 1'b0);          // R9 zero
        convert(FULL, 1'b0, 1'b0);       // R9 full scale
        convert(341, 1'b1, 1'b0);        // R8 input moves after sample
        convert(682, 1'b0, 1'b1);        // R7 start while busy
        convert(1, 1'b0, 1'b0);          // R10 back to back
        convert(512, 1'b0, 1'b0);
        convert(511, 1'b1, 1'b0);
        @(posedge clk); #1;
        check("R5 done single cycle", int'(done), 0);
        check("R6 result kept idle", int'(result), 511);
        repeat (3) @(posedge clk);
        #1;
        check("R6 queue drained", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule